// File: doc/BRIEF.md
# Configuration Address/Data Access Port

This block gives a host a two-register window for reaching the configuration space of devices on a PCI-style bus. Software first writes a packed target word into the address register. That word holds an enable flag, the bus number, the device number, the function number and a dword register index. Software then reads or writes the data register. Each data access with the enable flag set sends exactly one 32-bit configuration transaction out on a request/response interface. The register-side access stays stalled, with ready low, until the response comes back. Sub-word updates are left to software, which does them as read-modify-write through the same window.

A single state machine runs the port through four states:
- `ST_IDLE`: waits for an access.
- `ST_ISSUE`: drives the one-cycle request.
- `ST_WAIT`: holds the register access until a response arrives.
- `ST_DONE`: presents the captured read data with ready high for one cycle.

The transitions are:
- `ST_IDLE` to `ST_ISSUE` on an enabled data access.
- `ST_ISSUE` to `ST_WAIT` unconditionally.
- `ST_WAIT` to `ST_DONE` when a response is valid.
- `ST_DONE` to `ST_IDLE` unconditionally.

Any other access does not leave `ST_IDLE`: address-register accesses, unmapped offsets and data accesses with the flag clear all complete in the cycle they are presented.

Top module: `cfg_access_port`

## Requirements
- R1: The address register is at byte offset 0x20. It resets to 0 and reads back the last 32-bit value written to it.
- R2: A launched request carries the address word's bits 23:16 as bus, 15:11 as device, 10:8 as function and 7:2 as dword index. Bits 1:0 have no effect on the request.
- R3: An access to any offset other than 0x20 or 0x24 completes in the cycle it is presented. A read there returns 0, a write there changes nothing, and no request starts.
- R4: While bit 31 of the address word is 1, a read of the data register at 0x24 starts exactly one request with write low. The read then returns the response data when the target reports it is present.
- R5: While bit 31 is 1, a write to the data register starts exactly one request with write high, carrying the written data as request data.
- R6: While bit 31 is 0, a data read returns 0xFFFFFFFF, a data write is dropped, and neither starts a request. Both complete in the cycle they are presented.
- R7: A response with the present flag low makes the data read return 0xFFFFFFFF, whatever the response data is.
- R8: The request valid is a single-cycle pulse, and only one request is outstanding at a time. Register ready stays low from launch until the cycle after the response. With a response D cycles after the request, ready first shows high D+2 cycles after the access is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access request, held until ready is seen |
| reg_wr | input | 1 | 1 for a register write, 0 for a read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while ready is high |
| reg_ready | output | 1 | Access completes at a clock edge where en and ready are both high |
| cfg_req_valid | output | 1 | One-cycle configuration request strobe |
| cfg_req_write | output | 1 | 1 for a configuration write |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_dev | output | 5 | Target device number |
| cfg_req_func | output | 3 | Target function number |
| cfg_req_dword | output | 6 | Target dword register index |
| cfg_req_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Response strobe |
| cfg_rsp_found | input | 1 | 1 when the target answered, 0 for an absent device |
| cfg_rsp_rdata | input | 32 | Response read data |

## Verification
The assertions assume the following about the host and the bus side:
- The host holds each register access steady until it sees ready.
- The host does not rewrite the address register while a data access is pending.
- The bus side answers each request with exactly one response pulse, no earlier than the cycle after the request.

The bench keeps to these rules. Its access task holds the inputs until ready and releases them one cycle later. Its bus responder only reacts to an observed request and waits a programmable delay of at least one cycle before answering.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int EN_BIT     = 31;
    localparam int BUS_LSB    = 16;
    localparam int BUS_W      = 8;
    localparam int DEV_LSB    = 11;
    localparam int DEV_W      = 5;
    localparam int FUNC_LSB   = 8;
    localparam int FUNC_W     = 3;
    localparam int DWORD_LSB  = 2;
    localparam int DWORD_W    = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } cfg_state_e;

    typedef struct packed {
        logic [BUS_W-1:0]   bus;
        logic [DEV_W-1:0]   dev;
        logic [FUNC_W-1:0]  func;
        logic [DWORD_W-1:0] dword;
    } cfg_target_t;

endpackage

// File: rtl/cfg_reg_decode.sv
module cfg_reg_decode #(
    parameter int          AW       = 8,
    parameter logic [AW-1:0] ADDR_OFS = 8'h20,
    parameter logic [AW-1:0] DATA_OFS = 8'h24
) (
    input  logic [AW-1:0] offset,
    output logic          hit_addr,
    output logic          hit_data
);

    always_comb begin
        hit_addr = (offset == ADDR_OFS);
        hit_data = (offset == DATA_OFS);
    end

endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_port_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] word_q,
    output logic          enabled,
    output cfg_target_t   target
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wdata;
        end
    end

    always_comb begin
        enabled      = word_q[EN_BIT];
        target.bus   = word_q[BUS_LSB   +: BUS_W];
        target.dev   = word_q[DEV_LSB   +: DEV_W];
        target.func  = word_q[FUNC_LSB  +: FUNC_W];
        target.dword = word_q[DWORD_LSB +: DWORD_W];
    end

endmodule

// File: rtl/cfg_txn_fsm.sv
module cfg_txn_fsm
    import cfg_port_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic          hit_addr,
    input  logic          hit_data,
    input  logic          cfg_on,
    input  logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] addr_word,
    output logic          acc_ready,
    output logic [DW-1:0] acc_rdata,
    output logic          idle,
    output logic          req_valid,
    output logic          req_write,
    output logic [DW-1:0] req_wdata,
    input  logic          rsp_valid,
    input  logic          rsp_found,
    input  logic [DW-1:0] rsp_rdata,
    output cfg_state_e    state_o
);

    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

    cfg_state_e    state_q, state_d;
    logic          launch;
    logic          wr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rsp_q;

    assign launch = acc_en && hit_data && cfg_on;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transaction capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rsp_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && launch) begin
                wr_q    <= acc_wr;
                wdata_q <= acc_wdata;
            end
            if (state_q == ST_WAIT && rsp_valid) begin
                rsp_q <= rsp_found ? rsp_rdata : ALL_ONES;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_ready = 1'b0;
        acc_rdata = '0;
        req_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acc_ready = !launch;
                if (hit_addr) begin
                    acc_rdata = addr_word;
                end else if (hit_data) begin
                    acc_rdata = ALL_ONES;
                end
            end
            ST_ISSUE: req_valid = 1'b1;
            ST_WAIT:  acc_ready = 1'b0;
            ST_DONE: begin
                acc_ready = 1'b1;
                acc_rdata = rsp_q;
            end
            default: acc_ready = 1'b0;
        endcase
    end

    assign idle      = (state_q == ST_IDLE);
    assign req_write = wr_q;
    assign req_wdata = wdata_q;
    assign state_o   = state_q;

endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
    import cfg_port_pkg::*;
#(
    parameter int            DW       = 32,
    parameter int            AW       = 8,
    parameter logic [AW-1:0] ADDR_OFS = 8'h20,
    parameter logic [AW-1:0] DATA_OFS = 8'h24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_en,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_ready,
    output logic          cfg_req_valid,
    output logic          cfg_req_write,
    output logic [7:0]    cfg_req_bus,
    output logic [4:0]    cfg_req_dev,
    output logic [2:0]    cfg_req_func,
    output logic [5:0]    cfg_req_dword,
    output logic [DW-1:0] cfg_req_wdata,
    input  logic          cfg_rsp_valid,
    input  logic          cfg_rsp_found,
    input  logic [DW-1:0] cfg_rsp_rdata
);

    logic          hit_addr;
    logic          hit_data;
    logic          fsm_idle;
    logic          addr_wr;
    logic          cfg_on;
    logic [DW-1:0] addr_word;
    cfg_target_t   target;
    cfg_state_e    txn_state;

    cfg_reg_decode #(
        .AW       (AW),
        .ADDR_OFS (ADDR_OFS),
        .DATA_OFS (DATA_OFS)
    ) u_decode (
        .offset   (reg_addr),
        .hit_addr (hit_addr),
        .hit_data (hit_data)
    );

    assign addr_wr = reg_en && reg_wr && hit_addr && fsm_idle;

    cfg_addr_reg #(
        .DW (DW)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (addr_wr),
        .wdata   (reg_wdata),
        .word_q  (addr_word),
        .enabled (cfg_on),
        .target  (target)
    );

    cfg_txn_fsm #(
        .DW (DW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (reg_en),
        .acc_wr    (reg_wr),
        .hit_addr  (hit_addr),
        .hit_data  (hit_data),
        .cfg_on    (cfg_on),
        .acc_wdata (reg_wdata),
        .addr_word (addr_word),
        .acc_ready (reg_ready),
        .acc_rdata (reg_rdata),
        .idle      (fsm_idle),
        .req_valid (cfg_req_valid),
        .req_write (cfg_req_write),
        .req_wdata (cfg_req_wdata),
        .rsp_valid (cfg_rsp_valid),
        .rsp_found (cfg_rsp_found),
        .rsp_rdata (cfg_rsp_rdata),
        .state_o   (txn_state)
    );

    assign cfg_req_bus   = target.bus;
    assign cfg_req_dev   = target.dev;
    assign cfg_req_func  = target.func;
    assign cfg_req_dword = target.dword;

endmodule

// File: rtl/cfg_access_port_checker.sv
module cfg_access_port_checker
    import cfg_port_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input cfg_state_e    state,
    input logic [DW-1:0] addr_word,
    input logic          reg_ready,
    input logic [DW-1:0] reg_rdata,
    input logic          cfg_req_valid,
    input logic [7:0]    cfg_req_bus,
    input logic [4:0]    cfg_req_dev,
    input logic [2:0]    cfg_req_func,
    input logic [5:0]    cfg_req_dword,
    input logic          cfg_rsp_valid,
    input logic          cfg_rsp_found,
    input logic [DW-1:0] cfg_rsp_rdata
);

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |=> !cfg_req_valid); // R8

    AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !reg_ready); // R8

    AST_LAUNCH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> addr_word[EN_BIT]); // R6

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> ($stable(cfg_req_bus) && $stable(cfg_req_dev)
                                && $stable(cfg_req_func) && $stable(cfg_req_dword))); // R2

    AST_ABSENT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(cfg_rsp_valid && !cfg_rsp_found))
            |-> (reg_rdata == {DW{1'b1}})); // R7

    AST_PRESENT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(cfg_rsp_valid && cfg_rsp_found))
            |-> (reg_rdata == $past(cfg_rsp_rdata))); // R4

endmodule

bind cfg_access_port cfg_access_port_checker #(.DW(DW)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (txn_state),
    .addr_word     (addr_word),
    .reg_ready     (reg_ready),
    .reg_rdata     (reg_rdata),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_bus   (cfg_req_bus),
    .cfg_req_dev   (cfg_req_dev),
    .cfg_req_func  (cfg_req_func),
    .cfg_req_dword (cfg_req_dword),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_found (cfg_rsp_found),
    .cfg_rsp_rdata (cfg_rsp_rdata)
);

// File: tb/cfg_access_port_bench.sv
module cfg_access_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic        cfg_req_valid;
    logic        cfg_req_write;
    logic [7:0]  cfg_req_bus;
    logic [4:0]  cfg_req_dev;
    logic [2:0]  cfg_req_func;
    logic [5:0]  cfg_req_dword;
    logic [31:0] cfg_req_wdata;
    logic        cfg_rsp_valid = 1'b0;
    logic        cfg_rsp_found = 1'b0;
    logic [31:0] cfg_rsp_rdata = 32'h0;

    int checks = 0;
    int fails  = 0;
    int rsp_delay = 1;
    int req_cnt = 0;
    logic        last_write;
    logic [7:0]  last_bus;
    logic [4:0]  last_dev;
    logic [2:0]  last_func;
    logic [5:0]  last_dword;
    logic [31:0] last_wdata;
    logic [31:0] mem [4][64];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_port u_cfg_access_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_en        (reg_en),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .reg_ready     (reg_ready),
        .cfg_req_valid (cfg_req_valid),
        .cfg_req_write (cfg_req_write),
        .cfg_req_bus   (cfg_req_bus),
        .cfg_req_dev   (cfg_req_dev),
        .cfg_req_func  (cfg_req_func),
        .cfg_req_dword (cfg_req_dword),
        .cfg_req_wdata (cfg_req_wdata),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_found (cfg_rsp_found),
        .cfg_rsp_rdata (cfg_rsp_rdata)
    );

    // Bus-side responder: present devices are bus 0, device 0..3.
    initial begin
        for (int d = 0; d < 4; d++)
            for (int w = 0; w < 64; w++)
                mem[d][w] = 32'h5A000000 | (d << 8) | w;
        forever begin
            @(negedge clk);
            if (cfg_req_valid) begin
                req_cnt++;
                last_write = cfg_req_write;
                last_bus   = cfg_req_bus;
                last_dev   = cfg_req_dev;
                last_func  = cfg_req_func;
                last_dword = cfg_req_dword;
                last_wdata = cfg_req_wdata;
                repeat (rsp_delay) @(negedge clk);
                cfg_rsp_valid = 1'b1;
                if (last_bus == 8'd0 && last_dev < 5'd4) begin
                    cfg_rsp_found = 1'b1;
                    cfg_rsp_rdata = mem[last_dev[1:0]][last_dword];
                    if (last_write) mem[last_dev[1:0]][last_dword] = last_wdata;
                end else begin
                    cfg_rsp_found = 1'b0;
                    cfg_rsp_rdata = 32'h00001234;
                end
                @(negedge clk);
                cfg_rsp_valid = 1'b0;
                cfg_rsp_found = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one register access; returns read data and the number of wait cycles
    task automatic access(input logic wr, input logic [7:0] off, input logic [31:0] wd,
                          output logic [31:0] rd, output int waits);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = wr; reg_addr = off; reg_wdata = wd;
        waits = 0;
        forever begin
            #1;
            if (reg_ready || waits > 500) break;
            @(negedge clk);
            waits++;
        end
        rd = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    // {wr, offset, wdata, expected read data}
    localparam logic [72:0] VEC [NVEC] = '{
        {1'b1, 8'h20, 32'h8000080C, 32'h0},          // R1 dev1 dword3
        {1'b0, 8'h20, 32'h0, 32'h8000080C},          // R1 readback
        {1'b0, 8'h24, 32'h0, 32'h5A000103},          // R4 present read
        {1'b1, 8'h24, 32'hCAFEF00D, 32'h0},          // R5 data write
        {1'b0, 8'h24, 32'h0, 32'hCAFEF00D},          // R4 R5 write landed
        {1'b1, 8'h20, 32'h8000281C, 32'h0},          // R7 dev5 absent
        {1'b0, 8'h24, 32'h0, 32'hFFFFFFFF},          // R7 absent read
        {1'b1, 8'h20, 32'h800010FF, 32'h0},          // R2 low bits set
        {1'b0, 8'h24, 32'h0, 32'h5A00023F},          // R2 low bits ignored
        {1'b0, 8'h20, 32'h0, 32'h800010FF}           // R1 readback
    };

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          w;
        int          base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state, R1
        access(1'b0, 8'h20, 32'h0, rd, w);
        chk("R1 reset value", rd, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][72], VEC[i][71:64], VEC[i][63:32], rd, w);
            if (!VEC[i][72]) chk($sformatf("R1/R2/R4/R5/R7 vector %0d", i), rd, VEC[i][31:0]);
        end

        // R5: request fields of a data write
        access(1'b1, 8'h20, 32'h8000080C, rd, w);
        access(1'b1, 8'h24, 32'h0BADBEEF, rd, w);
        chk("R5 write flag", {31'b0, last_write}, 32'h1);
        chk("R5 write data", last_wdata, 32'h0BADBEEF);

        // R2: field unpacking with nonzero bus and function
        access(1'b1, 8'h20, 32'h80AB0E40, rd, w);
        access(1'b0, 8'h24, 32'h0, rd, w);
        chk("R2 bus", {24'b0, last_bus}, 32'hAB);
        chk("R2 dev", {27'b0, last_dev}, 32'h1);
        chk("R2 func", {29'b0, last_func}, 32'h6);
        chk("R2 dword", {26'b0, last_dword}, 32'h10);
        chk("R4 read flag", {31'b0, last_write}, 32'h0);

        // R3: unmapped offset
        access(1'b1, 8'h20, 32'h8000080C, rd, w);
        base = req_cnt;
        access(1'b1, 8'h28, 32'h12345678, rd, w);
        chk("R3 write immediate", w, 0);
        access(1'b0, 8'h28, 32'h0, rd, w);
        chk("R3 read zero", rd, 32'h0);
        chk("R3 read immediate", w, 0);
        access(1'b0, 8'h20, 32'h0, rd, w);
        chk("R3 address untouched", rd, 32'h8000080C);
        chk("R3 no request", req_cnt, base);

        // R6: enable bit clear
        access(1'b1, 8'h20, 32'h0000080C, rd, w);
        access(1'b0, 8'h24, 32'h0, rd, w);
        chk("R6 disabled read ones", rd, 32'hFFFFFFFF);
        chk("R6 disabled read immediate", w, 0);
        access(1'b1, 8'h24, 32'h11111111, rd, w);
        chk("R6 disabled write immediate", w, 0);
        chk("R6 no request", req_cnt, base);
        access(1'b1, 8'h20, 32'h8000080C, rd, w);
        access(1'b0, 8'h24, 32'h0, rd, w);
        chk("R6 write dropped", rd, 32'h0BADBEEF);

        // R8: wait timing and a single request per access
        rsp_delay = 5;
        base = req_cnt;
        access(1'b0, 8'h24, 32'h0, rd, w);
        chk("R8 ready after delay+2", w, 7);
        chk("R8 one request", req_cnt, base + 1);
        chk("R8 data after long wait", rd, 32'h0BADBEEF);
        rsp_delay = 1;
        access(1'b0, 8'h24, 32'h0, rd, w);
        chk("R8 ready after delay+2 short", w, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule